// File: doc/BRIEF.md
# Host Byte Mailbox Port (device side)

This block is the device end of a two-register byte mailbox on a simple host I/O bus. Offset 0 is the data port. Offset 1 is the command/status port: a write there is a command byte, and a read there returns the status flags. Command and data bytes accepted from the host are handed to an internal core over a valid/ready byte stream that also carries a kind flag. Response bytes come back from the core on a second valid/ready stream with an end-of-response marker.

The port owns the status flags and decodes the mode-changing commands. It wraps every response in framing markers: a start marker, the payload, and an end marker, each offered through the data port. A dedicated abort command brings the port back to a clean ready-for-command state from any condition. This includes a stalled core that never takes a pending byte.

Top module: `mbox_port`

## Requirements
- R1: After reset the status byte reads 0x10 (only the ready-for-command flag set), no byte is offered to the core, and the abort pulse is low.
- R2: The status byte has output-buffer-full at bit 0, input-buffer-full at bit 1, the framing flag at bit 2, last-write-target at bit 3, ready-for-command at bit 4 and ready-for-data at bit 5. Bits 7:6 read 0. Reading status has no side effect.
- R3: A host write accepted at either port sets input-buffer-full and offers the byte to the core on the next cycle. The kind flag is 1 for the command port and 0 for the data port. Input-buffer-full clears on the cycle after the core's handshake.
- R4: A host write made while input-buffer-full is set is dropped, and the offered byte and kind stay unchanged. An abort write is the exception.
- R5: Last-write-target is 1 after an accepted command-port write and 0 after an accepted data-port write.
- R6: When the core takes command 0x01, ready-for-data becomes 1 and ready-for-command becomes 0. When it takes command 0x03, the two flags swap back. Any other command code leaves them unchanged. Exactly one of the two flags is set at any time.
- R7: A data-port write while ready-for-data is 0 is dropped: input-buffer-full stays 0 and last-write-target keeps its value.
- R8: Each response is presented as a start byte 0x01 with the framing flag set, then each payload byte with the framing flag clear, then an end byte 0x03 with the framing flag set. Output-buffer-full is set while each of these bytes is held.
- R9: A data-port read while output-buffer-full is set clears output-buffer-full and the framing flag. The next byte is loaded one cycle later if it is available.
- R10: The port asks the core for a payload byte only while output-buffer-full is 0 and a response has been started but not yet ended.
- R11: Writing 0x22 to the command port in any state clears input-buffer-full, output-buffer-full, the framing flag and ready-for-data, and sets ready-for-command and last-write-target. The 0x22 byte is not forwarded to the core, and the abort output pulses for exactly one cycle on the following cycle.
- R12: A data-port read while output-buffer-full is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 1 | 0 selects the data port, 1 the command/status port |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWdata | input | DATA_W | Host write byte |
| hostRdata | output | DATA_W | Read data for the selected port (combinational) |
| inValid | output | 1 | A host byte is offered to the core |
| inReady | input | 1 | Core takes the offered byte |
| inData | output | DATA_W | Offered byte |
| inIsCmd | output | 1 | Offered byte came from the command port |
| respValid | input | 1 | Core has a response payload byte |
| respReady | output | 1 | Port takes the response byte |
| respData | input | DATA_W | Response payload byte |
| respLast | input | 1 | This payload byte ends the response |
| coreAbort | output | 1 | One-cycle abort pulse to the core |

## Verification
The bench builds the port with its defaults: an 8-bit data width, start code 0x01, end code 0x03 and abort code 0x22. These are the byte values a host driver uses, so the bench can drive full exchanges as a driver would. It covers long and one-byte responses, payload bytes that equal the marker or abort codes, and aborts issued against a stalled core and in the middle of a response. The behavioural model uses the same codes to predict every status read and every stream handshake on each cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // status bit positions (host software decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_FRM = 2;
  localparam int ST_TGT = 3;
  localparam int ST_RDC = 4;
  localparam int ST_RDD = 5;
  localparam int ST_BITS = 6;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_BODY = 2'd1,
    RSP_TAIL = 2'd2
  } rspState_e;

  typedef enum logic [1:0] {
    SRC_START   = 2'd0,
    SRC_PAYLOAD = 2'd1,
    SRC_END     = 2'd2
  } outSrc_e;

  typedef struct packed {
    logic    inLoad;
    logic    inKind;
    logic    outLoad;
    outSrc_e outSrc;
  } dpStrobe_t;
endpackage

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] START_CODE = 8'h01,
  parameter logic [DATA_W-1:0] END_CODE   = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] respData,
  output logic [DATA_W-1:0] heldByte,
  output logic              heldIsCmd,
  output logic [DATA_W-1:0] outByte
);
  logic [DATA_W-1:0] outNext;

  always_comb begin
    unique case (strobe.outSrc)
      SRC_START:   outNext = START_CODE;
      SRC_PAYLOAD: outNext = respData;
      SRC_END:     outNext = END_CODE;
      default:     outNext = outByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldByte  <= '0;
      heldIsCmd <= 1'b0;
      outByte   <= '0;
    end else begin
      if (strobe.inLoad) begin
        heldByte  <= hostWdata;
        heldIsCmd <= strobe.inKind;
      end
      if (strobe.outLoad) begin
        outByte <= outNext;
      end
    end
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] START_CODE = 8'h01,
  parameter logic [DATA_W-1:0] END_CODE   = 8'h03,
  parameter logic [DATA_W-1:0] ABORT_CODE = 8'h22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              inReady,
  input  logic              respValid,
  input  logic              respLast,
  input  logic [DATA_W-1:0] heldByte,
  input  logic              heldIsCmd,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] statusVec,
  output logic              inValid,
  output logic              respReady,
  output logic              coreAbort
);
  logic      ibfQ, obfQ, frmQ, tgtQ, dataPhaseQ, abortQ;
  rspState_e rspQ;

  logic cancelWr, cmdWr, datWr, take, acceptCmd, acceptDat, dataRd, outLoad;

  always_comb begin
    cancelWr  = hostWr && hostAddr && (hostWdata == ABORT_CODE);
    cmdWr     = hostWr && hostAddr && !cancelWr;
    datWr     = hostWr && !hostAddr;
    take      = ibfQ && inReady;
    acceptCmd = cmdWr && !ibfQ;
    acceptDat = datWr && !ibfQ && dataPhaseQ;
    dataRd    = hostRd && !hostAddr && obfQ;
    outLoad   = !obfQ && !cancelWr && ((rspQ == RSP_TAIL) || respValid);
  end

  always_comb begin
    strobe.inLoad  = !cancelWr && (acceptCmd || acceptDat);
    strobe.inKind  = acceptCmd;
    strobe.outLoad = outLoad;
    unique case (rspQ)
      RSP_IDLE: strobe.outSrc = SRC_START;
      RSP_BODY: strobe.outSrc = SRC_PAYLOAD;
      default:  strobe.outSrc = SRC_END;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibfQ       <= 1'b0;
      obfQ       <= 1'b0;
      frmQ       <= 1'b0;
      tgtQ       <= 1'b0;
      dataPhaseQ <= 1'b0;
      abortQ     <= 1'b0;
      rspQ       <= RSP_IDLE;
    end else begin
      abortQ <= cancelWr;
      if (cancelWr) begin
        ibfQ       <= 1'b0;
        obfQ       <= 1'b0;
        frmQ       <= 1'b0;
        tgtQ       <= 1'b1;
        dataPhaseQ <= 1'b0;
        rspQ       <= RSP_IDLE;
      end else begin
        // inbound side
        if (take) begin
          ibfQ <= 1'b0;
          if (heldIsCmd && heldByte == START_CODE) dataPhaseQ <= 1'b1;
          else if (heldIsCmd && heldByte == END_CODE) dataPhaseQ <= 1'b0;
        end
        if (acceptCmd || acceptDat) begin
          ibfQ <= 1'b1;
          tgtQ <= acceptCmd;
        end
        // outbound side
        if (dataRd) begin
          obfQ <= 1'b0;
          frmQ <= 1'b0;
        end else if (outLoad) begin
          obfQ <= 1'b1;
          unique case (rspQ)
            RSP_IDLE: begin
              frmQ <= 1'b1;
              rspQ <= RSP_BODY;
            end
            RSP_BODY: begin
              frmQ <= 1'b0;
              rspQ <= respLast ? RSP_TAIL : RSP_BODY;
            end
            default: begin
              frmQ <= 1'b1;
              rspQ <= RSP_IDLE;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    statusVec         = '0;
    statusVec[ST_OBF] = obfQ;
    statusVec[ST_IBF] = ibfQ;
    statusVec[ST_FRM] = frmQ;
    statusVec[ST_TGT] = tgtQ;
    statusVec[ST_RDC] = !dataPhaseQ;
    statusVec[ST_RDD] = dataPhaseQ;
    inValid           = ibfQ;
    respReady         = !obfQ && (rspQ == RSP_BODY);
    coreAbort         = abortQ;
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] START_CODE = 8'h01,
  parameter logic [DATA_W-1:0] END_CODE   = 8'h03,
  parameter logic [DATA_W-1:0] ABORT_CODE = 8'h22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              inValid,
  input  logic              inReady,
  output logic [DATA_W-1:0] inData,
  output logic              inIsCmd,
  input  logic              respValid,
  output logic              respReady,
  input  logic [DATA_W-1:0] respData,
  input  logic              respLast,
  output logic              coreAbort
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] statusVec;
  logic [DATA_W-1:0] heldByte;
  logic              heldIsCmd;
  logic [DATA_W-1:0] outByte;

  mbox_ctrl #(
    .DATA_W(DATA_W), .START_CODE(START_CODE),
    .END_CODE(END_CODE), .ABORT_CODE(ABORT_CODE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .inReady(inReady),
    .respValid(respValid), .respLast(respLast), .heldByte(heldByte),
    .heldIsCmd(heldIsCmd), .strobe(strobe), .statusVec(statusVec),
    .inValid(inValid), .respReady(respReady), .coreAbort(coreAbort)
  );

  mbox_dp #(
    .DATA_W(DATA_W), .START_CODE(START_CODE), .END_CODE(END_CODE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(hostWdata),
    .respData(respData), .heldByte(heldByte), .heldIsCmd(heldIsCmd),
    .outByte(outByte)
  );

  assign hostRdata = hostAddr ? statusVec : outByte;
  assign inData    = heldByte;
  assign inIsCmd   = heldIsCmd;
endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ABORT_CODE = 8'h22
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAddr,
  input logic              hostWr,
  input logic              hostRd,
  input logic [DATA_W-1:0] hostWdata,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inData,
  input logic              inIsCmd,
  input logic              respReady,
  input logic              coreAbort,
  input logic [DATA_W-1:0] statusVec
);
  logic abortWr;
  assign abortWr = hostWr && hostAddr && (hostWdata == ABORT_CODE);

  // R3: a taken byte is no longer offered
  a_r3_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !abortWr |=> !inValid);

  // R4: an untaken byte stays put
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !inReady && !abortWr |=> inValid && $stable(inData) && $stable(inIsCmd));

  // R6: exactly one of the two mode flags
  a_r6_mode_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[4] != statusVec[5]);

  // R8: framing flag only with a held byte
  a_r8_frame_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    statusVec[2] |-> statusVec[0]);

  // R9: a data read empties the output buffer
  a_r9_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && !hostAddr && statusVec[0] && !abortWr |=> !statusVec[0]);

  // R10: ask for payload only when empty
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    respReady |-> !statusVec[0]);

  // R11: abort returns to a clean command-ready state and pulses the core
  a_r11_abort_recovers: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> (statusVec[5:0] == 6'h18) && coreAbort && !inValid);
endmodule

bind mbox_port mbox_port_chk #(.DATA_W(DATA_W), .ABORT_CODE(ABORT_CODE)) uChk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
  .hostWdata(hostWdata), .inValid(inValid), .inReady(inReady), .inData(inData),
  .inIsCmd(inIsCmd), .respReady(respReady), .coreAbort(coreAbort),
  .statusVec(statusVec)
);

// File: tb/tb_mbox_port.sv
`timescale 1ns/100ps
module tb_mbox_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostAddr = 1'b1;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       inValid;
  logic       inReady = 1'b0;
  logic [7:0] inData;
  logic       inIsCmd;
  logic       respValid = 1'b0;
  logic       respReady;
  logic [7:0] respData = '0;
  logic       respLast = 1'b0;
  logic       coreAbort;

  always #2.5 clk = ~clk;

  mbox_port dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inIsCmd(inIsCmd),
    .respValid(respValid), .respReady(respReady), .respData(respData),
    .respLast(respLast), .coreAbort(coreAbort)
  );

  int    nTests = 0;
  int    nFail = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  bit       mIbf, mInCmd, mObf, mFrm, mTgt, mData, mAbort;
  bit [7:0] mIn, mOut;
  int       mRsp;
  byte unsigned rq[$];

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit [7:0] st, expRd;
    bit       ab, pop;
    bit       nIbf, nInCmd, nObf, nFrm, nTgt, nData;
    bit [7:0] nIn, nOut;
    int       nRsp;
    respValid = rq.size() > 0;
    respData  = (rq.size() > 0) ? rq[0] : 8'h00;
    respLast  = rq.size() == 1;
    #1;
    st    = {2'b00, mData, !mData, mTgt, mFrm, mIbf, mObf};
    expRd = hostAddr ? st : mOut;
    chk(hostAddr ? "status" : "data", hostRdata, expRd);
    chk("inValid", {7'd0, inValid}, {7'd0, mIbf});
    if (mIbf) begin
      chk("inData", inData, mIn);
      chk("inIsCmd", {7'd0, inIsCmd}, {7'd0, mInCmd});
    end
    chk("respReady", {7'd0, respReady}, {7'd0, (!mObf && mRsp == 1)});
    chk("coreAbort", {7'd0, coreAbort}, {7'd0, mAbort});
    // next state from the requirements
    ab = hostWr && hostAddr && hostWdata == 8'h22;
    nIbf = mIbf; nInCmd = mInCmd; nObf = mObf; nFrm = mFrm; nTgt = mTgt;
    nData = mData; nIn = mIn; nOut = mOut; nRsp = mRsp; pop = 1'b0;
    if (ab) begin
      nIbf = 0; nObf = 0; nFrm = 0; nTgt = 1; nData = 0; nRsp = 0;
      rq.delete();
    end else begin
      if (mIbf && inReady) begin
        nIbf = 0;
        if (mInCmd && mIn == 8'h01) nData = 1;
        else if (mInCmd && mIn == 8'h03) nData = 0;
      end
      if (hostWr && !mIbf && (hostAddr || mData)) begin
        nIbf = 1; nIn = hostWdata; nInCmd = hostAddr; nTgt = hostAddr;
      end
      if (hostRd && !hostAddr && mObf) begin
        nObf = 0; nFrm = 0;
      end else if (!mObf) begin
        if (mRsp == 0 && rq.size() > 0) begin
          nOut = 8'h01; nFrm = 1; nObf = 1; nRsp = 1;
        end else if (mRsp == 1 && rq.size() > 0) begin
          nOut = rq[0]; nFrm = 0; nObf = 1; nRsp = (rq.size() == 1) ? 2 : 1; pop = 1;
        end else if (mRsp == 2) begin
          nOut = 8'h03; nFrm = 1; nObf = 1; nRsp = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    if (pop) void'(rq.pop_front());
    mIbf = nIbf; mInCmd = nInCmd; mObf = nObf; mFrm = nFrm; mTgt = nTgt;
    mData = nData; mIn = nIn; mOut = nOut; mRsp = nRsp; mAbort = ab;
    hostWr = 0; hostRd = 0; hostAddr = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic wrCmd(input logic [7:0] b);
    hostAddr = 1'b1; hostWr = 1'b1; hostWdata = b; step();
  endtask
  task automatic wrData(input logic [7:0] b);
    hostAddr = 1'b0; hostWr = 1'b1; hostWdata = b; step();
  endtask
  task automatic rdData();
    hostAddr = 1'b0; hostRd = 1'b1; step();
  endtask
  task automatic peekData();
    hostAddr = 1'b0; step();
  endtask
  task automatic drainResp(input int n);
    for (int i = 0; i < n; i++) begin
      idle(1);
      peekData();
      rdData();
    end
  endtask

  initial begin
    mIbf = 0; mInCmd = 0; mObf = 0; mFrm = 0; mTgt = 0; mData = 0; mAbort = 0;
    mIn = 0; mOut = 0; mRsp = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    curReq = "R1"; idle(2);
    curReq = "R12"; rdData(); peekData();
    curReq = "R7"; wrData(8'h55); idle(2);
    curReq = "R3"; wrCmd(8'h01); idle(2);
    curReq = "R4"; wrCmd(8'h05); wrData(8'h66); idle(1);
    curReq = "R6"; inReady = 1'b1; idle(1); inReady = 1'b0; idle(2);
    curReq = "R5"; wrData(8'hA5); idle(1); inReady = 1'b1; idle(1);
    wrData(8'h3C); wrData(8'h22); idle(1); wrData(8'h01); idle(1);
    curReq = "R6"; wrCmd(8'h07); idle(2);
    wrData(8'h9E); idle(1);
    wrCmd(8'h03); idle(2);
    curReq = "R7"; wrData(8'h11); idle(1);
    curReq = "R2"; idle(1); peekData();
    inReady = 1'b0;
    curReq = "R8"; rq = '{8'h10, 8'h03, 8'h01, 8'h22};
    drainResp(7);
    curReq = "R9"; rq = '{8'hC7};
    idle(2); rdData(); rdData(); rdData(); idle(1); rdData(); idle(2); rdData();
    curReq = "R10"; rq = '{8'h44, 8'h45};
    idle(1); idle(3); rdData(); rdData(); idle(2);
    curReq = "R12"; peekData(); rdData(); idle(1); drainResp(3);
    curReq = "R11"; wrCmd(8'h01); idle(2); wrCmd(8'h22); idle(2);
    wrCmd(8'h01); inReady = 1'b1; idle(1); inReady = 1'b0; wrData(8'h77); idle(2);
    rq = '{8'h01, 8'h02, 8'h03}; idle(3); rdData(); idle(1);
    wrCmd(8'h22); idle(3); peekData();
    curReq = "R3"; inReady = 1'b1; wrCmd(8'h01); idle(1); wrData(8'h5A); idle(1);
    wrCmd(8'h03); idle(2); inReady = 1'b0;
    curReq = "R8"; rq = '{8'hEE}; drainResp(4);
    curReq = "R1"; idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog %s: actual hung expected done", curReq);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule